// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose 16-bit timer. A free-running counter outside the block supplies its value, together with a one-cycle pulse on each wrap. The channel works in one of two modes. In capture mode it timestamps edges on its pin. In compare mode it drives its pin when the counter reaches a programmed value. Either kind of event sets a channel flag, and that flag can raise an interrupt request.

Software reaches the channel through a byte-wide register port with three locations: an 8-bit control byte, the high byte of the 16-bit channel value and the low byte. Writing the high byte holds off compare matches until the low byte follows. Reading the high byte snapshots the low byte, so a 16-bit value that capture can change is always read as a consistent pair. Two control bits add pin toggling on counter wrap and a forced-high output for full duty.

Top module: `tcc_channel`

## Requirements
- R1: After reset the control byte reads 0x00, irq is 0 and pin_oe is 0.
- R2: Control byte bit positions, MSB first: 7 flag, 6 interrupt enable, 5 spare mode bit (stored only), 4 mode (0 capture, 1 compare), 3:2 action select, 1 overflow toggle, 0 full duty. Bits 6..0 read back as written.
- R3: In capture mode the action select picks the edge: 00 none, 01 rising, 10 falling, 11 both. On an active edge the counter value is copied into the channel value and the flag is set. Without an active edge the channel value is unchanged.
- R4: In compare mode the flag is set on the first cycle in which the counter equals the channel value. At that same moment the pin is toggled (01), cleared (10) or set (11). While the counter holds the equal value there is no further action.
- R5: pin_oe is 1 only in compare mode with a non-zero action select. The flag is still set on a match when the action select is 00.
- R6: The flag clears only when a control read that sees the flag at 1 is followed by a control write with bit 7 at 0. A write of 1, or a write of 0 with no prior read, leaves the flag unchanged.
- R7: irq is the flag gated by the interrupt enable.
- R8: Writing the high byte (address 1) suppresses compare matches until the low byte (address 2) is written. A match pending at that point occurs on the next cycle.
- R9: A read of the high byte freezes the value returned at the low-byte address until the low byte is read, even if a capture happens in between.
- R10: In compare mode with overflow toggle set, each counter wrap toggles the pin. A compare match in the same cycle takes priority over the wrap.
- R11: In compare mode with both overflow toggle and full duty set, pin_out is held at 1 whatever the compare action does.
- R12: Address 0 reads the control byte, address 1 the high byte, address 2 the low byte and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 16 | Shared counter value |
| cnt_ovf | input | 1 | One-cycle pulse on counter wrap |
| pin_in | input | 1 | Channel pin level (capture source) |
| pin_out | output | 1 | Channel pin drive value |
| pin_oe | output | 1 | Channel pin drive enable |
| irq | output | 1 | Interrupt request |
| addr | input | 2 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |

## Verification
The assertions watch several things on every cycle. A selected rising edge must load the counter into the channel value and set the flag. The flag may rise only after a pin change or a counter match, and may fall only after a control write with bit 7 at 0. A pending high-byte write must block flag rises. Toggle actions on a match and on a wrap must flip the pin. The bench scenarios cover behaviour that spans several accesses: the read-then-write sequence for clearing the flag, the frozen low byte across an intervening capture, priority between a match and a wrap, the full-duty override, and the checks that a stimulus had no effect.

// File: rtl/tcc_channel.sv
module tcc_channel #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_ovf,
  input  logic          pin_in,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq,
  input  logic [1:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic          flag, ie, msb, msa, tov, maxd;
  logic [1:0]    els;
  logic          arm, inh, frz, pin_q, pin_r, match_q;
  logic [CW-1:0] chan;
  logic [DW-1:0] lo_hold;

  wire ctl_wr = wr && addr == 2'd0;
  wire hi_wr  = wr && addr == 2'd1;
  wire lo_wr  = wr && addr == 2'd2;
  wire ctl_rd = rd && addr == 2'd0;
  wire hi_rd  = rd && addr == 2'd1;
  wire lo_rd  = rd && addr == 2'd2;

  wire rise   = pin_in & ~pin_q;
  wire fall   = ~pin_in & pin_q;
  wire cap_ev = !msa && ((els[0] && rise) || (els[1] && fall));
  wire match  = msa && !inh && cnt == chan;
  wire cmp_ev = match && !match_q;
  wire ev     = cap_ev || cmp_ev;
  wire drive  = msa && els != 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {flag, ie, msb, msa, els, tov, maxd} <= '0;
      arm     <= 1'b0;
      inh     <= 1'b0;
      frz     <= 1'b0;
      pin_q   <= 1'b0;
      pin_r   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      pin_q   <= pin_in;
      match_q <= match;

      if (ctl_wr) {ie, msb, msa, els, tov, maxd} <= wdata[6:0];

      if (ev) flag <= 1'b1;
      else if (ctl_wr && arm && !wdata[7]) flag <= 1'b0;

      if (ev) arm <= 1'b0;
      else if (ctl_rd && flag) arm <= 1'b1;
      else if (ctl_wr) arm <= 1'b0;

      if (lo_wr) inh <= 1'b0;
      else if (hi_wr) inh <= 1'b1;

      if (hi_rd) frz <= 1'b1;
      else if (lo_rd) frz <= 1'b0;

      if (drive) begin
        if (cmp_ev) begin
          case (els)
            2'b01:   pin_r <= ~pin_r;
            2'b10:   pin_r <= 1'b0;
            default: pin_r <= 1'b1;
          endcase
        end else if (tov && cnt_ovf) begin
          pin_r <= ~pin_r;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap_ev) chan <= cnt;
    else begin
      if (hi_wr) chan[CW-1:DW] <= wdata;
      if (lo_wr) chan[DW-1:0]  <= wdata;
    end
    if (hi_rd) lo_hold <= chan[DW-1:0];
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {flag, ie, msb, msa, els, tov, maxd};
      2'd1:    rdata = chan[CW-1:DW];
      2'd2:    rdata = frz ? lo_hold : chan[DW-1:0];
      default: rdata = '0;
    endcase
  end

  assign pin_oe  = drive;
  assign pin_out = (drive && tov && maxd) ? 1'b1 : pin_r;
  assign irq     = flag & ie;
endmodule

module tcc_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          cnt_ovf,
  input logic          pin_in,
  input logic          pin_out,
  input logic [1:0]    addr,
  input logic          wr,
  input logic          wd7,
  input logic          flag,
  input logic          msa,
  input logic [1:0]    els,
  input logic          tov,
  input logic          maxd,
  input logic          inh,
  input logic          pin_q,
  input logic          match_q,
  input logic [CW-1:0] chan
);
  wire ctl_wr = wr && addr == 2'd0;

  p_capture_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!msa && els[0] && pin_in && !pin_q) |=> (flag && chan == $past(cnt)));

  p_flag_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(pin_in != pin_q || cnt == chan));

  p_match_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (msa && els == 2'b01 && !tov && !inh && cnt == chan && !match_q && !ctl_wr)
      |=> pin_out != $past(pin_out));

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(ctl_wr && !wd7));

  p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msa && inh) |=> !$rose(flag));

  p_wrap_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msa && els == 2'b01 && tov && !maxd && cnt_ovf && !ctl_wr
      && !(cnt == chan && !inh && !match_q))
      |=> pin_out != $past(pin_out));
endmodule

bind tcc_channel tcc_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_ovf(cnt_ovf), .pin_in(pin_in),
  .pin_out(pin_out), .addr(addr), .wr(wr), .wd7(wdata[7]), .flag(flag),
  .msa(msa), .els(els), .tov(tov), .maxd(maxd), .inh(inh), .pin_q(pin_q),
  .match_q(match_q), .chan(chan)
);

// File: tb/tcc_channel_tb.sv
`timescale 1ns/1ps
module tcc_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        cnt_ovf = 1'b0;
  logic        pin_in = 1'b0;
  logic [1:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic        pin_out, pin_oe, irq;
  logic [7:0]  rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tcc_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_ovf(cnt_ovf), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .addr(addr), .rd(rd),
    .wr(wr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    step();
    rd = 1'b0;
  endtask

  function automatic logic [7:0] mk(bit ie, bit cmp, logic [1:0] sel, bit ovt, bit full);
    return {1'b0, ie, 1'b0, cmp, sel, ovt, full};
  endfunction

  function automatic bit cap_hit(logic [1:0] sel, bit old_p, bit new_p);
    return (sel[0] && !old_p && new_p) || (sel[1] && old_p && !new_p);
  endfunction

  function automatic bit cmp_pin(logic [1:0] sel, bit p);
    case (sel)
      2'b01:   return !p;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return p;
    endcase
  endfunction

  task automatic clear_flag(string req);
    logic [7:0] d;
    bus_rd(2'd0, d);
    bus_wr(2'd0, d & 8'h7F);
    bus_rd(2'd0, d);
    chk(req, d[7], 0);
  endtask

  task automatic set_chan(logic [15:0] v);
    bus_wr(2'd1, v[15:8]);
    bus_wr(2'd2, v[7:0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  d, hi, lo;
    logic [15:0] last, v, c;
    logic [1:0]  e;
    bit p, np, hit, pp, ep;
    void'($urandom(32'd7));

    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    bus_rd(2'd0, d);
    chk("R1 ctl", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 oe", pin_oe, 0);

    // R2 control readback, R12 unused address
    bus_wr(2'd0, 8'h6F);
    bus_rd(2'd0, d);
    chk("R2 readback", d, 8'h6F);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd3, d);
    chk("R12 addr3", d, 8'h00);

    // R3 directed rising capture
    bus_wr(2'd0, mk(1, 0, 2'b01, 0, 0));
    cnt = 16'h1111; pin_in = 1'b1;
    step();
    p = 1'b1; last = 16'h1111;
    chk("R7 irq on capture", irq, 1);
    bus_rd(2'd1, hi); bus_rd(2'd2, lo);
    chk("R3 captured", {hi, lo}, 16'h1111);

    // R6 clearing sequence
    bus_wr(2'd0, mk(1, 0, 2'b01, 0, 0) | 8'h00);
    chk("R6 write0 no read", irq, 1);
    bus_wr(2'd0, mk(1, 0, 2'b01, 0, 0) | 8'h80);
    chk("R6 write1", irq, 1);
    clear_flag("R6 cleared");
    chk("R6 irq low", irq, 0);
    bus_wr(2'd0, mk(1, 0, 2'b01, 0, 0) | 8'h80);
    chk("R6 write1 when clear", irq, 0);

    // R3 random captures
    for (int i = 0; i < 40; i++) begin
      e = 2'($urandom % 4);
      bus_wr(2'd0, mk(1, 0, e, 0, 0));
      c = 16'($urandom);
      np = 1'($urandom % 2);
      cnt = c; pin_in = np;
      step();
      hit = cap_hit(e, p, np);
      p = np;
      chk("R7 irq follows capture", irq, hit);
      bus_rd(2'd1, hi); bus_rd(2'd2, lo);
      chk("R3 capture value", {hi, lo}, hit ? c : last);
      if (hit) begin
        last = c;
        clear_flag("R6 after capture");
      end
    end

    // R4/R5 directed compare toggle
    pp = 1'b0;
    v = 16'h5A5A;
    cnt = 16'h0000;
    set_chan(v);
    bus_wr(2'd0, mk(1, 1, 2'b01, 0, 0));
    chk("R5 oe compare", pin_oe, 1);
    chk("R4 pin before", pin_out, 0);
    cnt = v - 16'd1; step();
    chk("R4 no early match", pin_out, 0);
    cnt = v; step();
    chk("R4 toggle", pin_out, 1);
    chk("R4 flag irq", irq, 1);
    repeat (3) step();
    chk("R4 single action", pin_out, 1);
    pp = 1'b1;
    clear_flag("R6 compare");

    // R4 random compares
    for (int i = 0; i < 20; i++) begin
      v = 16'($urandom);
      cnt = ~v; step();
      set_chan(v);
      e = 2'($urandom % 3 + 1);
      bus_wr(2'd0, mk(1, 1, e, 0, 0));
      cnt = v; step();
      ep = cmp_pin(e, pp);
      chk("R4 action", pin_out, ep);
      chk("R7 irq match", irq, 1);
      clear_flag("R6 compare loop");
      pp = ep;
    end

    // R5 action 00: no drive, flag still set; R7 gated
    cnt = ~v; step();
    bus_wr(2'd0, mk(0, 1, 2'b00, 0, 0));
    chk("R5 oe off", pin_oe, 0);
    cnt = v; step();
    chk("R7 irq gated", irq, 0);
    bus_rd(2'd0, d);
    chk("R5 flag set", d[7], 1);
    bus_wr(2'd0, mk(0, 1, 2'b00, 0, 0));

    // R8 inhibit
    cnt = ~v; step();
    bus_wr(2'd0, mk(1, 1, 2'b01, 0, 0));
    bus_wr(2'd1, v[15:8]);
    cnt = v;
    repeat (3) step();
    chk("R8 pin held", pin_out, pp);
    chk("R8 no flag", irq, 0);
    bus_wr(2'd2, v[7:0]);
    step();
    chk("R8 match after low", pin_out, !pp);
    chk("R8 flag after low", irq, 1);
    pp = !pp;
    clear_flag("R6 inhibit");

    // R9 frozen low byte
    bus_wr(2'd0, mk(0, 0, 2'b01, 0, 0));
    pin_in = 1'b0; step();
    cnt = 16'h1234; pin_in = 1'b1; step();
    bus_rd(2'd1, hi);
    chk("R9 hi", hi, 8'h12);
    pin_in = 1'b0; step();
    cnt = 16'hABCD; pin_in = 1'b1; step();
    bus_rd(2'd2, lo);
    chk("R9 frozen lo", lo, 8'h34);
    bus_rd(2'd1, hi); bus_rd(2'd2, lo);
    chk("R9 new value", {hi, lo}, 16'hABCD);
    clear_flag("R6 freeze");

    // R10 wrap toggle and priority
    v = 16'hABCD;
    cnt = 16'h0F0F; step();
    bus_wr(2'd0, mk(0, 1, 2'b01, 1, 0));
    cnt_ovf = 1'b1; step(); cnt_ovf = 1'b0;
    chk("R10 wrap toggle", pin_out, !pp);
    pp = !pp;
    bus_wr(2'd0, mk(0, 1, 2'b11, 1, 0));
    if (!pp) begin
      cnt_ovf = 1'b1; step(); cnt_ovf = 1'b0;
      pp = 1'b1;
    end
    chk("R10 pin high", pin_out, 1);
    cnt = v; cnt_ovf = 1'b1; step(); cnt_ovf = 1'b0;
    chk("R10 match wins", pin_out, 1);
    clear_flag("R6 wrap");

    // R11 full duty
    cnt = 16'h0F0F; step();
    bus_wr(2'd0, mk(0, 1, 2'b10, 1, 1));
    cnt = v; step();
    chk("R11 forced high", pin_out, 1);
    bus_wr(2'd0, mk(0, 1, 2'b10, 1, 0));
    chk("R11 released", pin_out, 0);
    clear_flag("R6 full duty");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule